// File: doc/BRIEF.md
# Signed/Unsigned Fractional Multiplier Unit

This block is the 8x8 multiply engine of a small 8-bit RISC core. The core hands it two register operands and a 3-bit operation code. The code selects whether each operand is read as unsigned or two's complement, and whether the product is used as an integer or as a fixed-point fraction. The unit returns a 16-bit product and two flags, a zero flag and a carry flag. The core writes the product into its fixed result register pair, high byte to the upper register and low byte to the lower one. The core also merges the two flags into its status register and leaves every other flag untouched. Writeback, decode and stalling stay in the core.

Requests enter through a valid/ready port. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` falls for exactly one cycle after a request is taken. `in_valid` raised during that cycle has no effect, so the caller must hold its request until `in_ready` returns. The result side has no back-pressure: the latency is fixed, and `done` pulses once when the product and flags are new. These outputs then hold their values until the next result.

Top module: `mulx_unit`

## Requirements
- R1: `in_ready` is high whenever the unit is idle or in its `done` cycle, and low during its `busy` cycle. A request is taken only on an edge where `in_valid` and `in_ready` are both high. `in_valid` asserted while `in_ready` is low starts nothing and does not alter the pending result.
- R2: For a request taken at edge A, `busy` is high in the cycle after A. `done` is high for exactly one cycle, the second cycle after A, and `product`, `flag_z` and `flag_c` carry that request's result from then on.
- R3: Bits `op[1:0]` select operand signedness, and `op[2]` set selects fractional form. The codes for `op[1:0]` are:
  - 00: both operands unsigned.
  - 01: both operands two's complement.
  - 10: `opnd_a` is two's complement and `opnd_b` is unsigned.
  - 11: behaves as 00.
- R4: In integer form (`op[2]`=0), `product` is the exact 16-bit product under the selected signedness, in two's complement when either operand is signed.
- R5: In fractional form (`op[2]`=1), `product` is the integer product shifted left by one bit, with bit 15 dropped, bit 0 zero and no saturation. Signed 0x80 x 0x80 therefore gives 0x8000.
- R6: `flag_c` equals bit 15 of the integer product before any fractional shift.
- R7: `flag_z` is 1 exactly when the 16-bit `product` as delivered (after any shift) is zero.
- R8: After reset, `product`, `flag_z`, `flag_c`, `busy` and `done` are 0 and `in_ready` is 1. Outputs change only at the edge that starts a `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| op | input | 3 | Operation code: [2] fractional, [1:0] signedness |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse: new result on outputs |
| product | output | 16 | Result for the register pair |
| flag_z | output | 1 | Zero flag of the result |
| flag_c | output | 1 | Carry flag (bit 15 before shift) |

## Verification
The bench aims at the corner cases of operand extension. These are 0x80 and 0xFF in each signed mode, and the signed-by-unsigned mix where only `opnd_a` may be negative. A swapped or missing sign extension shows up as a wrong high byte. The fractional cases include signed 0x80 x 0x80. A design that saturates would return 0x7FFF, and one that takes the carry after the shift would report the wrong `flag_c`. Zero results, both from a zero operand and in fractional form, confirm that `flag_z` is taken from the delivered value. A request raised during the busy cycle must leave the pending product alone and must not produce a second `done`. A design that accepted it would overwrite the result or pulse `done` twice.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
  typedef enum logic [1:0] {
    SG_UU  = 2'b00,
    SG_SS  = 2'b01,
    SG_SU  = 2'b10,
    SG_RSV = 2'b11
  } sign_mode_e;

  typedef struct packed {
    logic a_signed;
    logic b_signed;
    logic frac;
  } op_ctl_t;

  // R3: code 11 falls back to unsigned x unsigned
  function automatic op_ctl_t decode_op(input logic [2:0] code);
    op_ctl_t c;
    c.frac = code[2];
    unique case (sign_mode_e'(code[1:0]))
      SG_SS:   begin c.a_signed = 1'b1; c.b_signed = 1'b1; end
      SG_SU:   begin c.a_signed = 1'b1; c.b_signed = 1'b0; end
      default: begin c.a_signed = 1'b0; c.b_signed = 1'b0; end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/mulx_operand_ext.sv
module mulx_operand_ext #(
  parameter int W = 8,
  localparam int XW = 2 * W
) (
  input  logic [W-1:0]  opnd,
  input  logic          is_signed,
  output logic [XW-1:0] opnd_x
);
  logic fill;
  assign fill   = is_signed & opnd[W-1];
  assign opnd_x = {{W{fill}}, opnd};
endmodule

// File: rtl/mulx_pp_array.sv
module mulx_pp_array #(
  parameter int W = 8,
  localparam int XW = 2 * W
) (
  input  logic [XW-1:0] a_x,
  input  logic [XW-1:0] b_x,
  output logic [XW-1:0] raw
);
  logic [XW-1:0] row [XW];
  logic [XW-1:0] acc [XW+1];

  assign acc[0] = '0;

  for (genvar i = 0; i < XW; i++) begin : g_row
    assign row[i]   = (a_x & {XW{b_x[i]}}) << i;
    assign acc[i+1] = acc[i] + row[i];
  end

  assign raw = acc[XW];
endmodule

// File: rtl/mulx_post.sv
module mulx_post #(
  parameter int W = 8,
  localparam int XW = 2 * W
) (
  input  logic [XW-1:0] raw,
  input  logic          frac,
  output logic [XW-1:0] result,
  output logic          zero,
  output logic          carry
);
  assign result = frac ? {raw[XW-2:0], 1'b0} : raw;
  assign carry  = raw[XW-1];
  assign zero   = (result == '0);
endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
  import mulx_pkg::*;
#(
  parameter int W = 8,
  localparam int XW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    op,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  output logic          busy,
  output logic          done,
  output logic [XW-1:0] product,
  output logic          flag_z,
  output logic          flag_c
);
  op_ctl_t       ctl;
  logic          accept;
  logic [XW-1:0] a_x, b_x, a_x_q, b_x_q;
  logic          frac_q, busy_q, done_q;
  logic [XW-1:0] raw, res_d, prod_q;
  logic          z_d, c_d, z_q, c_q;

  assign ctl    = decode_op(op);
  assign accept = in_valid & ~busy_q;

  mulx_operand_ext #(.W(W)) u_ext_a (.opnd(opnd_a), .is_signed(ctl.a_signed), .opnd_x(a_x));
  mulx_operand_ext #(.W(W)) u_ext_b (.opnd(opnd_b), .is_signed(ctl.b_signed), .opnd_x(b_x));

  // stage 1: capture extended operands
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_x_q  <= '0;
      b_x_q  <= '0;
      frac_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= accept;
      if (accept) begin
        a_x_q  <= a_x;
        b_x_q  <= b_x;
        frac_q <= ctl.frac;
      end
    end
  end

  mulx_pp_array #(.W(W)) u_array (.a_x(a_x_q), .b_x(b_x_q), .raw(raw));
  mulx_post     #(.W(W)) u_post  (.raw(raw), .frac(frac_q), .result(res_d), .zero(z_d), .carry(c_d));

  // stage 2: register result and flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_q;
      if (busy_q) begin
        prod_q <= res_d;
        z_q    <= z_d;
        c_q    <= c_d;
      end
    end
  end

  assign in_ready = ~busy_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign product  = prod_q;
  assign flag_z   = z_q;
  assign flag_c   = c_q;

  a_r1_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept, 2) |-> done);
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_frac_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (done && frac_q) |-> (product[0] == 1'b0));
  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_z == (product == '0)));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> ($stable(product) && $stable(flag_z) && $stable(flag_c)));
endmodule

// File: tb/mulx_unit_bench.sv
module mulx_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  op = '0;
  logic [7:0]  opnd_a = '0, opnd_b = '0;
  logic        busy, done;
  logic [15:0] product;
  logic        flag_z, flag_c;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mulx_unit u_mulx_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy), .done(done),
    .product(product), .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
      summary();
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // returns {carry, zero, product}, from the requirement text
  function automatic logic [17:0] model(logic [2:0] code, logic [7:0] a, logic [7:0] b);
    int av, bv, p;
    logic [15:0] raw, res;
    av = (code[1:0] == 2'b01 || code[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
    bv = (code[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
    p = av * bv;
    raw = p[15:0];
    res = code[2] ? {raw[14:0], 1'b0} : raw;
    return {raw[15], (res == 16'h0), res};
  endfunction

  function automatic string tag(logic [2:0] code);
    if (code[2]) return "R5";
    return (code[1:0] == 2'b00) ? "R4" : "R3";
  endfunction

  // issue one request; optionally raise a stray request during the busy cycle
  task automatic run_op(logic [2:0] code, logic [7:0] a, logic [7:0] b, bit stray);
    logic [17:0] e;
    e = model(code, a, b);
    @(negedge clk);
    check("R1 ready before issue", in_ready, 1);
    in_valid = 1'b1; op = code; opnd_a = a; opnd_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 busy cycle", {busy, done, in_ready}, 3'b100);
    if (stray) begin
      in_valid = 1'b1; op = ~code; opnd_a = ~a; opnd_b = b ^ 8'h5A;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 done cycle", {busy, done}, 2'b01);
    check(tag(code), product, e[15:0]);
    check("R7 zero", flag_z, e[16]);
    check("R6 carry", flag_c, e[17]);
    if (stray) begin
      @(negedge clk);
      check("R1 stray request ignored", {busy, done}, 2'b00);
      check("R8 hold after stray", {flag_c, flag_z, product}, e);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R8 reset outputs", {busy, done, flag_z, flag_c, product}, '0);
    check("R8 reset ready", in_ready, 1);
    rst_n = 1'b1;

    run_op(3'b000, 8'hFF, 8'hFF, 0);   // 0xFE01
    run_op(3'b001, 8'hFF, 8'hFF, 0);   // R3 signed: 1
    run_op(3'b010, 8'hFF, 8'hFF, 0);   // R3 mixed: 0xFF01
    run_op(3'b011, 8'hFF, 8'hFF, 0);   // R3 reserved as unsigned
    run_op(3'b001, 8'h80, 8'h80, 0);   // 0x4000
    run_op(3'b101, 8'h80, 8'h80, 0);   // R5 wrap to 0x8000
    run_op(3'b100, 8'hFF, 8'hFF, 0);   // R5 frac unsigned, R6 carry from raw
    run_op(3'b110, 8'h80, 8'hFF, 0);   // mixed frac
    run_op(3'b001, 8'h7F, 8'h80, 0);
    run_op(3'b000, 8'h00, 8'hA5, 0);   // R7 zero
    run_op(3'b101, 8'h00, 8'h80, 0);   // R7 zero fractional
    run_op(3'b010, 8'h01, 8'h80, 1);   // R1 stray while busy

    for (int i = 0; i < 400; i++) begin
      logic [2:0] c;
      c = 3'($urandom_range(0, 7));
      run_op(c, 8'($urandom), 8'($urandom), ($urandom_range(0, 3) == 0));
    end

    @(negedge clk);
    check("R8 idle after run", {busy, done}, 2'b00);
    summary();
  end
endmodule